// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block sequences a multi-register block transfer between a register file and memory. A request presents a base address, a 16-bit mask of selected registers, a load/store select, one of four addressing modes and a writeback flag. The sequencer then issues one word access per selected register, in ascending register order. Each access carries the register index and the word address, and a new access can be issued every cycle.

All four modes place the lowest-numbered selected register at the lowest address of the block. The start address is therefore computed once, when the request is accepted, and each accepted access moves the address up by one word. When the block ends, the sequencer raises a one-cycle completion pulse. If writeback was requested, it presents the updated base with that pulse. Once a transfer has begun it runs to the end, and new requests arriving in the meantime are dropped.

Top module: `blkx_seq`

## Requirements
- R1: After reset, `busy`, `done`, `memValid` and `baseWbValid` are low.
- R2: A request with N bits set in `regMask` produces exactly N accepted accesses, with `regIdx` walking the set bits from the lowest to the highest. `memValid` is never high while `busy` is low.
- R3: `mode` encoding: bit 1 = decrement, bit 0 = before. With mode 0 (increment after), the first address is `baseAddr`, and each later access is 4 above the previous one.
- R4: With mode 1 (increment before), the first address is `baseAddr + 4`.
- R5: With mode 2 (decrement after), the first address is `baseAddr - 4N + 4`, so the last access lands on `baseAddr`.
- R6: With mode 3 (decrement before), the first address is `baseAddr - 4N`, so the last access lands on `baseAddr - 4`.
- R7: While `memValid` is high and `memReady` is low, `memAddr` and `regIdx` hold. An access counts only in a cycle where both are high.
- R8: `done` is high for exactly one cycle, the cycle after the last accepted access. `busy` is low in that cycle. With `memReady` held high, `done` arrives N cycles after the start edge.
- R9: `baseWbValid` is high exactly in the `done` cycle of a request that had `wrBack` set. `baseWbData` is then `baseAddr + 4N` for modes 0 and 1 and `baseAddr - 4N` for modes 2 and 3. A store in mode 1 with writeback, followed by a load in mode 2 from the written-back base, returns the base to its original value.
- R10: An empty `regMask` produces no access. `done` is raised in the first cycle after the start edge, and the writeback value equals `baseAddr`.
- R11: `start` is acted on only when `busy` and `done` are both low. A request made during a transfer changes neither its accesses nor its writeback value.
- R12: `memWrite` is the inverse of `isLoad` as sampled at the start edge, and it holds for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a block transfer |
| isLoad | input | 1 | 1 = memory to registers, 0 = registers to memory |
| mode | input | 2 | Addressing mode (bit 1 decrement, bit 0 before) |
| wrBack | input | 1 | Produce an updated base at completion |
| baseAddr | input | 32 | Base address of the block |
| regMask | input | 16 | Selected registers |
| memReady | input | 1 | Memory accepts the current access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| memValid | output | 1 | Access request valid |
| memWrite | output | 1 | Access is a store |
| memAddr | output | 32 | Word address of the access |
| regIdx | output | 4 | Register index of the access |
| baseWbValid | output | 1 | Updated base is valid |
| baseWbData | output | 32 | Updated base value |

## Verification
Acceptance of the final access and a fresh `start` request can fall in the same cycle, as can a stall and a request made mid-transfer. The bench raises `start` with a different mask and base one cycle into a running transfer. It then confirms that the access sequence, its count and the writeback value all match the first request only. The writeback pulse always coincides with `done`, so the bench samples both in the same cycle. A separate case stalls every other cycle, to show that addresses hold across a stall and that `done` still follows only the last accepted access.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request and precomputed addresses
    logic advance;   // retire current register, step address
  } dpCtrl_t;

endpackage

// File: rtl/blkx_low_pick.sv
module blkx_low_pick #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] vec,
  output logic [NUM_REGS-1:0] lowOh,
  output logic [IDX_W-1:0]    lowIdx,
  output logic                anySet,
  output logic                oneLeft
);

  // isolate lowest set bit
  assign lowOh   = vec & (~vec + NUM_REGS'(1));
  assign anySet  = |vec;
  assign oneLeft = anySet && ((vec & (vec - NUM_REGS'(1))) == '0);

  // encode one-hot position; OR tree over bit positions
  logic [IDX_W-1:0] encPart [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_enc
    assign encPart[g] = lowOh[g] ? IDX_W'(g) : '0;
  end

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      lowIdx = lowIdx | encPart[i];
    end
  end

endmodule

// File: rtl/blkx_datapath.sv
module blkx_datapath
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int CNT_W  = $clog2(NUM_REGS + 1),
  localparam int SHIFT  = $clog2(WORD_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [1:0]          mode,
  input  logic                isLoad,
  input  logic                wrBack,
  output logic [ADDR_W-1:0]   curAddr,
  output logic [IDX_W-1:0]    curIdx,
  output logic                remAny,
  output logic                remLast,
  output logic                reqEmpty,
  output logic                opWrite,
  output logic                opWb,
  output logic [ADDR_W-1:0]   wbData
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NUM_REGS-1:0] remMask;
  logic [NUM_REGS-1:0] retireOh;
  logic [CNT_W-1:0]    regCnt;
  logic [ADDR_W-1:0]   span;
  logic [ADDR_W-1:0]   lowAddr;
  logic [ADDR_W-1:0]   wbCalc;
  addrMode_e           modeE;

  assign modeE    = addrMode_e'(mode);
  assign reqEmpty = (regMask == '0);

  // population count of the incoming mask
  always_comb begin
    regCnt = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      regCnt = regCnt + CNT_W'(regMask[i]);
    end
  end

  assign span = ADDR_W'(regCnt) << SHIFT;

  // lowest address of the block, per mode
  always_comb begin
    unique case (modeE)
      AM_INC_AFTER:  lowAddr = baseAddr;
      AM_INC_BEFORE: lowAddr = baseAddr + STEP;
      AM_DEC_AFTER:  lowAddr = baseAddr - span + STEP;
      AM_DEC_BEFORE: lowAddr = baseAddr - span;
      default:       lowAddr = baseAddr;
    endcase
  end

  assign wbCalc = mode[1] ? (baseAddr - span) : (baseAddr + span);

  blkx_low_pick #(.NUM_REGS(NUM_REGS)) pick_i (
    .vec    (remMask),
    .lowOh  (retireOh),
    .lowIdx (curIdx),
    .anySet (remAny),
    .oneLeft(remLast)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remMask <= '0;
      curAddr <= '0;
      wbData  <= '0;
      opWrite <= 1'b0;
      opWb    <= 1'b0;
    end else if (ctl.capture) begin
      remMask <= regMask;
      curAddr <= lowAddr;
      wbData  <= wbCalc;
      opWrite <= ~isLoad;
      opWb    <= wrBack;
    end else if (ctl.advance) begin
      remMask <= remMask & ~retireOh;
      curAddr <= curAddr + STEP;
    end
  end

  // capture and advance never coincide
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.capture && ctl.advance)); // R11

endmodule

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
  import blkx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memReady,
  input  logic    reqEmpty,
  input  logic    remAny,
  input  logic    remLast,
  input  logic    opWb,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    memValid,
  output logic    wbValid
);

  seqState_e state, stateNxt;

  always_comb begin
    stateNxt    = state;
    ctl.capture = 1'b0;
    ctl.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          stateNxt    = reqEmpty ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        if (memReady) begin
          ctl.advance = 1'b1;
          if (remLast) stateNxt = ST_FIN;
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy     = (state == ST_XFER);
  assign memValid = busy;
  assign done     = (state == ST_FIN);
  assign wbValid  = done && opWb;

  AST_BUSY_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> remAny); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memReady && remLast) |=> done); // R8

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                isLoad,
  input  logic [1:0]          mode,
  input  logic                wrBack,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic                memReady,
  output logic                busy,
  output logic                done,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [IDX_W-1:0]    regIdx,
  output logic                baseWbValid,
  output logic [ADDR_W-1:0]   baseWbData
);

  dpCtrl_t ctl;
  logic    remAny, remLast, reqEmpty, opWb;

  blkx_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .memReady(memReady),
    .reqEmpty(reqEmpty),
    .remAny  (remAny),
    .remLast (remLast),
    .opWb    (opWb),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .memValid(memValid),
    .wbValid (baseWbValid)
  );

  blkx_datapath #(
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .WORD_BYTES(WORD_BYTES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .baseAddr(baseAddr),
    .regMask (regMask),
    .mode    (mode),
    .isLoad  (isLoad),
    .wrBack  (wrBack),
    .curAddr (memAddr),
    .curIdx  (regIdx),
    .remAny  (remAny),
    .remLast (remLast),
    .reqEmpty(reqEmpty),
    .opWrite (memWrite),
    .opWb    (opWb),
    .wbData  (baseWbData)
  );

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memAddr == $past(memAddr) + STEP)); // R3

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || regIdx > $past(regIdx))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(regIdx))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !memValid)); // R8

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    baseWbValid |-> done); // R9

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(memValid)) |-> $stable(memWrite)); // R12

endmodule

// File: tb/blkx_seq_tb.sv
module blkx_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isLoad = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        wrBack = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] regMask = '0;
  logic        memReady = 1'b1;
  logic        busy, done, memValid, memWrite, baseWbValid;
  logic [31:0] memAddr, baseWbData;
  logic [3:0]  regIdx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkx_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .mode(mode),
    .wrBack(wrBack), .baseAddr(baseAddr), .regMask(regMask), .memReady(memReady),
    .busy(busy), .done(done), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .regIdx(regIdx), .baseWbValid(baseWbValid),
    .baseWbData(baseWbData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  // runs one request; stall = memReady low on even cycles; poke = new start mid-run
  task automatic runOp(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                       input logic ld, input logic wb, input bit stall, input bit poke,
                       input string req, output logic [31:0] wbOut);
    int n = popc(m);
    logic [31:0] low;
    int k = 0;
    int cyc = 0;
    int nextBit = 0;
    bit held = 0;
    logic [31:0] heldAddr;
    logic [3:0]  heldIdx;
    int stallBad = 0;
    int seqBad = 0;
    int writeBad = 0;
    case (md)
      2'd0: low = b;
      2'd1: low = b + 32'd4;
      2'd2: low = b - 32'(4*n) + 32'd4;
      default: low = b - 32'(4*n);
    endcase
    @(negedge clk);
    start = 1'b1; baseAddr = b; regMask = m; mode = md; isLoad = ld; wrBack = wb;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 300) begin
      memReady = stall ? cyc[0] : 1'b1;
      if (poke && cyc == 1) begin
        start = 1'b1; baseAddr = b ^ 32'h5550; regMask = ~m; isLoad = ~ld; mode = ~md;
      end else start = 1'b0;
      #1;
      if (done) break;
      if (held && (memAddr != heldAddr || regIdx != heldIdx)) stallBad++;
      held = 0;
      if (memValid) begin
        if (memWrite != ~ld) writeBad++;
        if (memReady) begin
          while (nextBit < 16 && !m[nextBit]) nextBit++;
          if (nextBit > 15 || 32'(nextBit) != 32'(regIdx) ||
              memAddr != low + 32'(4*k)) begin
            seqBad++;
            $display("FAIL %s access %0d actual=%0h/%0h expected=%0h/%0h", req, k,
                     regIdx, memAddr, nextBit, low + 32'(4*k));
          end
          nextBit++;
          k++;
        end else begin
          held = 1; heldAddr = memAddr; heldIdx = regIdx;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(seqBad == 0, {req, " R2 address/index sequence"}, seqBad, 0);
    check(k == n, {req, " R2 access count"}, k, n);
    check(writeBad == 0, {req, " R12 memWrite"}, writeBad, 0);
    if (stall) check(stallBad == 0, {req, " R7 hold on stall"}, stallBad, 0);
    else       check(cyc == n, {req, " R8 done latency"}, cyc, n);
    check(done && !busy && !memValid, {req, " R8 done with busy low"}, {done, busy, memValid}, 3'b100);
    check(baseWbValid == wb, {req, " R9 writeback valid"}, baseWbValid, wb);
    if (wb) begin
      logic [31:0] e = md[1] ? b - 32'(4*n) : b + 32'(4*n);
      check(baseWbData == e, {req, " R9 writeback value"}, baseWbData, e);
    end
    wbOut = baseWbData;
    @(negedge clk); #1;
    check(!done && !memValid && !busy, {req, " R8/R11 idle after done"}, {done, memValid, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w1, w2;
    #(CLK_PERIOD * 2 + 3);
    // R1: reset state
    check(!busy && !done && !memValid && !baseWbValid, "R1 reset outputs",
          {busy, done, memValid, baseWbValid}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check(!busy && !done && !memValid, "R1 idle after reset", {busy, done, memValid}, 0);

    runOp(32'h0000_1000, 16'h00A5, 2'd0, 1'b0, 1'b1, 0, 0, "R3 inc-after store", w1);
    runOp(32'h0000_4000, 16'h8001, 2'd1, 1'b1, 1'b0, 0, 0, "R4 inc-before load", w1);
    runOp(32'h0000_2000, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1, 0, "R5 dec-after full stall", w1);
    runOp(32'h0000_0010, 16'h0110, 2'd3, 1'b1, 1'b1, 0, 0, "R6 dec-before load", w1);
    runOp(32'h0000_0008, 16'h0003, 2'd3, 1'b0, 1'b1, 0, 0, "R6 dec-before wrap", w1);
    runOp(32'h0000_3000, 16'h0000, 2'd3, 1'b0, 1'b1, 0, 0, "R10 empty list", w1);
    check(w1 == 32'h0000_3000, "R10 base unchanged", w1, 32'h3000);
    runOp(32'h0000_6000, 16'h0F0F, 2'd0, 1'b0, 1'b1, 0, 1, "R11 start during busy", w1);
    runOp(32'h0000_7000, 16'h4C02, 2'd1, 1'b1, 1'b1, 1, 1, "R11 start during stall", w1);
    // R9 pairing: store inc-before then load dec-after restores base
    runOp(32'h0000_8000, 16'h3006, 2'd1, 1'b0, 1'b1, 0, 0, "R9 paired store", w1);
    runOp(w1, 16'h3006, 2'd2, 1'b1, 1'b1, 0, 0, "R9 paired load", w2);
    check(w2 == 32'h0000_8000, "R9 paired base restored", w2, 32'h8000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule